// File: doc/BRIEF.md
# Trigger-Gated Grouped Channel Capture

This block takes digitized samples from a multi-channel front end and pushes them into a downstream FIFO. A run has two steps. First the block is armed. Then it waits for a trigger pulse that marks the start phase of the excitation waveform. Capture begins only after that trigger.

During a run the channels are handled four at a time. The block selects a group of four channels. It takes a programmed number of sample strobes from that group, with all four lanes sampled together on each strobe. It then moves to the next group. After the last group has delivered its count, the block returns to idle.

Each FIFO word holds the four lane samples of one strobe and the index of the first channel in the group. This lets the consumer split the data back into channels. If the FIFO is full when a word is due, that word is lost and a sticky overflow flag is raised. The next arm clears the flag.

Top module: `trig_group_acq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `fifo_wr`=0, `overflow`=0, `grp_sel`=0.
- R2: A `trig` pulse received while armed sets `busy` on the following clock. A `trig` received while idle and not armed leaves `busy` at 0.
- R3: Groups are captured in ascending order. `grp_sel` names the group being captured and holds for exactly the programmed number of accepted strobes before it advances.
- R4: Each accepted strobe with `fifo_full`=0 produces one `fifo_wr` pulse on the next cycle. The word's top field holds the channel index 4×group. Below it, lane k sits at bits [k×SAMPLE_W +: SAMPLE_W].
- R5: After the last group's final strobe, `busy` returns to 0. Any strobes that follow produce no writes.
- R6: A `trig` received during a run changes neither `busy` nor `grp_sel`.
- R7: A `smp_valid` strobe received while armed, before the trigger, is not written.
- R8: An accepted strobe that meets `fifo_full`=1 is not written. It sets `overflow`, which stays at 1, and the strobe still counts toward the group's sample count.
- R9: `arm` clears `overflow`, aborts any run in progress (`busy`=0, `grp_sel`=0) and waits for a new trigger.
- R10: The sample count per channel is taken from `cfg_samples` at the `arm` pulse. Later changes to that input have no effect on the armed run. A value of 0 means 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Arm pulse; latches count, clears overflow, aborts a run |
| cfg_samples | input | CNT_W | Samples per channel per trigger |
| trig | input | 1 | Waveform start-phase trigger pulse |
| smp_valid | input | 1 | Strobe: the four lanes of `smp_data` hold a sample |
| smp_data | input | 4×SAMPLE_W | Four simultaneous lane samples of the selected group |
| fifo_full | input | 1 | Downstream FIFO cannot take a word |
| grp_sel | output | GRP_W | Group of four channels currently selected |
| busy | output | 1 | A triggered run is in progress |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_data | output | GRP_W+2+4×SAMPLE_W | {first channel index, lane3..lane0} |
| overflow | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
The hardest case to reach from the ports is a full FIFO in the middle of a group while a run is active. The dropped strobe must still advance the count, and the group boundary after it must fall in the right place. The stimulus reaches it as follows. It arms with one sample count, changes `cfg_samples` after the arm, and triggers. It then raises `fifo_full` on exactly the final strobe of group 0 and checks that the next strobe is written under group 1. A stray trigger is also pulsed in mid-run, and `arm` is pulsed in the middle of a second run, to show the abort path.

// File: rtl/acq_pkg.sv
// Package: shared types for the grouped capture block.
// Assumes four lanes per group; the state encoding is internal only.
package acq_pkg;
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } acq_state_t;
endpackage

// File: rtl/acq_ctrl.sv
// Module: acq_ctrl
// Run sequencer. Waits for arm, then for trigger, then walks the channel
// groups in ascending order, counting accepted strobes per group.
// Assumes NUM_CH is a multiple of four; arm has priority over all else.
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    localparam int NUM_GRP = NUM_CH / LANES,
    localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [CNT_W-1:0] cfg_samples,
    input  logic             trig,
    input  logic             smp_valid,
    output logic [GRP_W-1:0] grp,
    output logic             busy,
    output logic             take
);
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GRP - 1);

    acq_state_t       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] n_lat;
    logic             cnt_end;
    logic             run_end;

    // Strobe accepted only while running and not being re-armed.
    assign take    = (st == ST_RUN) && smp_valid && !arm;
    assign cnt_end = (cnt == n_lat - CNT_W'(1));
    assign run_end = take && cnt_end && (grp == LAST_GRP);
    assign busy    = (st == ST_RUN);

    // State, group and strobe counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            grp   <= '0;
            cnt   <= '0;
            n_lat <= '0;
        end else if (arm) begin
            st    <= ST_ARMED;
            grp   <= '0;
            cnt   <= '0;
            n_lat <= cfg_samples;
        end else begin
            case (st)
                ST_ARMED: if (trig) st <= ST_RUN;
                ST_RUN: begin
                    if (take) begin
                        if (cnt_end) begin
                            cnt <= '0;
                            if (grp == LAST_GRP) begin
                                grp <= '0;
                                st  <= ST_IDLE;
                            end else begin
                                grp <= grp + GRP_W'(1);
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                default: st <= st;
            endcase
        end
    end

    p_trig_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && trig && !arm) |=> (st == ST_RUN));
    p_wait_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && !trig && !arm) |=> (st == ST_ARMED));
    p_run_ignores_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !smp_valid && !arm) |=>
        (st == ST_RUN && $stable(grp) && $stable(cnt)));
    p_end_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_end |=> (st == ST_IDLE));
    p_arm_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (st == ST_ARMED && grp == '0 && cnt == '0));
    p_grp_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cnt_end && grp != LAST_GRP) |=> (grp == $past(grp) + GRP_W'(1)));
endmodule

// File: rtl/acq_wr.sv
// Module: acq_wr
// FIFO write stage. Registers one word per accepted strobe, tagged with the
// first channel index of the group, and keeps the sticky overflow flag.
// Assumes fifo_full is valid in the cycle the strobe is accepted.
module acq_wr
    import acq_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int GRP_W    = 1,
    localparam int CH_W    = GRP_W + 2,
    localparam int WORD_W  = CH_W + LANES * SAMPLE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arm,
    input  logic                      take,
    input  logic [GRP_W-1:0]          grp,
    input  logic [LANES*SAMPLE_W-1:0] smp_data,
    input  logic                      fifo_full,
    output logic                      fifo_wr,
    output logic [WORD_W-1:0]         fifo_data,
    output logic                      overflow
);
    logic [LANES*SAMPLE_W-1:0] lanes_packed;

    // Lane repack: lane k of the group lands in slot k of the word.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes_packed[k*SAMPLE_W +: SAMPLE_W] = smp_data[k*SAMPLE_W +: SAMPLE_W];
    end

    // Write strobe and word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
        end else begin
            fifo_wr <= take && !fifo_full;
            if (take && !fifo_full) fifo_data <= {grp, 2'b00, lanes_packed};
        end
    end

    // Sticky overflow, cleared by arm.
    always_ff @(posedge clk) begin
        if (!rst_n)                 overflow <= 1'b0;
        else if (arm)               overflow <= 1'b0;
        else if (take && fifo_full) overflow <= 1'b1;
    end

    p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !fifo_full) |=> fifo_wr);
    p_no_write_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !fifo_wr);
    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && fifo_full) |=> (!fifo_wr && overflow));
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !arm) |=> overflow);
    p_arm_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !overflow);
endmodule

// File: rtl/trig_group_acq.sv
// Module: trig_group_acq (top)
// Trigger-gated capture of NUM_CH channels in groups of four into a FIFO.
// Assumes the source presents the group chosen by grp_sel on smp_data.
module trig_group_acq
    import acq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 16,
    localparam int NUM_GRP = NUM_CH / LANES,
    localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int WORD_W  = GRP_W + 2 + LANES * SAMPLE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arm,
    input  logic [CNT_W-1:0]          cfg_samples,
    input  logic                      trig,
    input  logic                      smp_valid,
    input  logic [LANES*SAMPLE_W-1:0] smp_data,
    input  logic                      fifo_full,
    output logic [GRP_W-1:0]          grp_sel,
    output logic                      busy,
    output logic                      fifo_wr,
    output logic [WORD_W-1:0]         fifo_data,
    output logic                      overflow
);
    logic take;

    // Elaboration check on the channel count.
    initial begin
        if (NUM_CH % LANES != 0 || NUM_CH < LANES)
            $error("NUM_CH must be a nonzero multiple of four");
    end

    acq_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .cfg_samples (cfg_samples),
        .trig        (trig),
        .smp_valid   (smp_valid),
        .grp         (grp_sel),
        .busy        (busy),
        .take        (take)
    );

    acq_wr #(.SAMPLE_W(SAMPLE_W), .GRP_W(GRP_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .take      (take),
        .grp       (grp_sel),
        .smp_data  (smp_data),
        .fifo_full (fifo_full),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .overflow  (overflow)
    );
endmodule

// File: tb/sim_trig_group_acq.sv
`timescale 1ns/1ps
module sim_trig_group_acq;
    localparam int NUM_CH = 8;
    localparam int SW     = 16;
    localparam int CW     = 16;
    localparam int NG     = NUM_CH / 4;
    localparam int GW     = 1;
    localparam int WW     = GW + 2 + 4 * SW;

    typedef struct packed {
        logic [7:0]  n;
        logic [15:0] base;
        logic [7:0]  writes;
    } vec_t;
    localparam vec_t VECS [3] = '{
        '{n: 8'd1, base: 16'h1000, writes: 8'd2},
        '{n: 8'd3, base: 16'h2000, writes: 8'd6},
        '{n: 8'd2, base: 16'h3000, writes: 8'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic [CW-1:0] cfg_samples = '0;
    logic trig = 1'b0;
    logic smp_valid = 1'b0;
    logic [4*SW-1:0] smp_data = '0;
    logic fifo_full = 1'b0;
    logic [GW-1:0] grp_sel;
    logic busy;
    logic fifo_wr;
    logic [WW-1:0] fifo_data;
    logic overflow;

    int n_checks = 0;
    int n_fail = 0;
    int n_writes;

    always #2.5 clk = ~clk;

    trig_group_acq #(.NUM_CH(NUM_CH), .SAMPLE_W(SW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_samples(cfg_samples),
        .trig(trig), .smp_valid(smp_valid), .smp_data(smp_data),
        .fifo_full(fifo_full), .grp_sel(grp_sel), .busy(busy),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    function automatic logic [4*SW-1:0] pat(input logic [15:0] base, input int g, input int s);
        logic [4*SW-1:0] d;
        for (int k = 0; k < 4; k++) d[k*SW +: SW] = base + 16'(g * 256 + s * 16 + k);
        return d;
    endfunction

    // One clock with inputs held from the previous negedge; outputs read after.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_arm(input int n);
        arm = 1'b1; cfg_samples = CW'(n); step(); arm = 1'b0;
    endtask

    task automatic do_trig();
        trig = 1'b1; step(); trig = 1'b0;
    endtask

    // Present one strobe for group g; check group select before, write after.
    task automatic feed(input int g, input logic [4*SW-1:0] d, input logic full,
                        input bit expect_wr, input string req);
        chk(grp_sel == GW'(g), "R3 grp_sel", 128'(grp_sel), 128'(g));
        smp_valid = 1'b1; smp_data = d; fifo_full = full;
        step();
        smp_valid = 1'b0; fifo_full = 1'b0;
        chk(fifo_wr == expect_wr, {req, " fifo_wr"}, 128'(fifo_wr), 128'(expect_wr));
        if (fifo_wr) n_writes++;
        if (expect_wr && fifo_wr)
            chk(fifo_data == {GW'(g), 2'b00, d}, "R4 word", 128'(fifo_data),
                128'({GW'(g), 2'b00, d}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(!busy && !fifo_wr && !overflow && grp_sel == '0, "R1 reset",
            128'({busy, fifo_wr, overflow, grp_sel}), 128'(0));

        // Table-driven runs
        for (int v = 0; v < 3; v++) begin
            n_writes = 0;
            do_arm(int'(VECS[v].n));
            do_trig();
            chk(busy == 1'b1, "R2 trig starts", 128'(busy), 128'(1));
            for (int g = 0; g < NG; g++)
                for (int s = 0; s < int'(VECS[v].n); s++)
                    feed(g, pat(VECS[v].base, g, s), 1'b0, 1'b1, "R4");
            chk(busy == 1'b0, "R5 run ends", 128'(busy), 128'(0));
            chk(n_writes == int'(VECS[v].writes), "R3 write count",
                128'(n_writes), 128'(VECS[v].writes));
        end

        // R5: strobe after end of run is not written
        feed(0, pat(16'h4000, 0, 0), 1'b0, 1'b0, "R5 idle strobe");

        // R2: trigger while idle (not armed) is ignored
        do_trig();
        chk(busy == 1'b0, "R2 unarmed trig", 128'(busy), 128'(0));

        // R7: strobe while armed, before trigger, not written
        do_arm(2);
        cfg_samples = CW'(5);   // R10: change after arm has no effect
        feed(0, pat(16'h5000, 0, 0), 1'b0, 1'b0, "R7 pre-trigger");
        chk(busy == 1'b0, "R7 still waiting", 128'(busy), 128'(0));
        do_trig();
        chk(busy == 1'b1, "R2 armed trig", 128'(busy), 128'(1));
        feed(0, pat(16'h5000, 0, 1), 1'b0, 1'b1, "R4");
        // R6: trigger mid-run ignored
        do_trig();
        chk(busy == 1'b1 && grp_sel == '0, "R6 mid-run trig",
            128'({busy, grp_sel}), 128'({1'b1, GW'(0)}));
        // R8: full on last strobe of group 0 drops word, sets overflow, still counts
        feed(0, pat(16'h5000, 0, 2), 1'b1, 1'b0, "R8 full drop");
        chk(overflow == 1'b1, "R8 overflow set", 128'(overflow), 128'(1));
        feed(1, pat(16'h5000, 1, 0), 1'b0, 1'b1, "R8 count advanced");
        feed(1, pat(16'h5000, 1, 1), 1'b0, 1'b1, "R10 latched count");
        chk(busy == 1'b0, "R10 count from arm", 128'(busy), 128'(0));
        chk(overflow == 1'b1, "R8 sticky", 128'(overflow), 128'(1));

        // R9: arm clears overflow and aborts a run
        do_arm(3);
        chk(overflow == 1'b0, "R9 arm clears", 128'(overflow), 128'(1'b0));
        do_trig();
        feed(0, pat(16'h6000, 0, 0), 1'b0, 1'b1, "R4");
        do_arm(1);
        chk(!busy && grp_sel == '0, "R9 abort", 128'({busy, grp_sel}), 128'(0));
        feed(0, pat(16'h6000, 0, 1), 1'b0, 1'b0, "R9 no write after abort");
        do_trig();
        chk(busy == 1'b1, "R9 retrigger", 128'(busy), 128'(1));
        feed(0, pat(16'h7000, 0, 0), 1'b0, 1'b1, "R4");
        feed(1, pat(16'h7000, 1, 0), 1'b0, 1'b1, "R4");
        chk(busy == 1'b0, "R5 run ends", 128'(busy), 128'(0));

        report();
    end
endmodule